// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address (a segment number and an offset into that segment) into one linear physical address. Each segment has a descriptor in a small on-chip table. The descriptor holds the segment's starting physical address, its length and two access-right bits. Before it adds the base, the translator checks three things: that the segment number is below a table-length register, that the offset lies inside the segment, and that the access kind is allowed. A request that fails a check comes back as a trap code in place of an address.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. The path has two register stages. The first reads the descriptor and the second checks and adds. A result waits in the output register until the consumer takes it (`rsp_valid && rsp_ready`). While it waits, the first stage can still hold one more request. When both stages are full and the output is stalled, `req_ready` goes low. Software loads the table entries, the table-base register and the table-length register through a plain configuration port. That port has effect only while `supervisor` is high.

Top module: `seg_xlat`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and the table-length register is 0, so every request traps with code 1.
- R2: A segment number greater than or equal to the table-length register gives trap code 1, with `rsp_paddr` equal to 0.
- R3: An offset greater than or equal to the selected descriptor's length gives trap code 2, with `rsp_paddr` equal to 0. For example, offset 14 in a segment of length 14 traps.
- R4: A request that passes all checks returns trap code 0 and `rsp_paddr = base + offset`. For example, base 219 with offset 430 gives 649.
- R5: Rights bit 0 grants reads and bit 1 grants writes (`req_write` = 1 marks a write). An access whose right bit is clear gives trap code 3, with `rsp_paddr` equal to 0.
- R6: When several checks fail, the reported code follows the priority segment number (1), then offset (2), then rights (3).
- R7: The descriptor used is the one in slot (table base + segment number) modulo 16, which wraps past the last slot.
- R8: `cfg_we` has effect only while `supervisor` is 1. Kind 0 writes slot `cfg_idx` with `cfg_base`, `cfg_len` and `cfg_rights`. Kind 1 loads the table base from `cfg_len[3:0]`. Kind 2 loads the table length from `cfg_len[5:0]`. Kind 3 does nothing.
- R9: A request accepted at a clock edge shows up on `rsp_*` after the next edge, provided the output register is free.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the output keeps its value. If the first stage is also full, `req_ready` is 0.
- R11: A request uses the table contents, base and length as they stood before its accepting edge. A configuration write at that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | Enables configuration writes while 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 entry, 1 table base, 2 table length, 3 none |
| cfg_idx | input | 4 | Slot written by kind 0 |
| cfg_base | input | 20 | Segment base for kind 0 |
| cfg_len | input | 16 | Segment length for kind 0; value for kinds 1 and 2 |
| cfg_rights | input | 2 | Bit 0 read, bit 1 write, for kind 0 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when both valid and ready are 1 |
| req_seg | input | 5 | Segment number |
| req_off | input | 16 | Offset in the segment |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 21 | Physical address, 0 on a trap |
| rsp_trap | output | 2 | 0 none, 1 segment number, 2 offset, 3 rights |

## Verification
The bench aims at the exact boundaries, where an offset equal to the segment length must trap and one less must translate. A `>` instead of `>=` lets the last byte plus one through. It also goes after requests that fail two checks at once, where a wrong priority order reports the wrong code, and after a table base that makes the slot index wrap, which breaks if the index is not taken modulo 16. Configuration writes arrive in the same cycle a request is accepted and again with `supervisor` low. A design that read the descriptor late, or that ignored the mode input, would return an address from the new base. A long stream with random back-pressure checks that a stalled result never changes and that no request is lost or duplicated.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int BASE_W   = 20;
  localparam int LEN_W    = 16;
  localparam int RIGHTS_W = 2;
  localparam int RD_BIT   = 0;
  localparam int WR_BIT   = 1;
  localparam int PA_W     = BASE_W + 1;

  typedef struct packed {
    logic [BASE_W-1:0]   base;
    logic [LEN_W-1:0]    len;
    logic [RIGHTS_W-1:0] rights;
  } seg_desc_t;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_SEG   = 2'd1,
    TRAP_LIMIT = 2'd2,
    TRAP_PROT  = 2'd3
  } trap_t;

  typedef enum logic [1:0] {
    CFG_ENTRY = 2'd0,
    CFG_TBASE = 2'd1,
    CFG_TLEN  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_kind_t;
endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table
  import segx_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output seg_desc_t        rd_desc
);
  seg_desc_t rows [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_row
    seg_desc_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        cell_q <= wr_desc;
    end
    assign rows[i] = cell_q;
  end

  // Registered read: the word seen is the one held before this edge's write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_desc <= '0;
    else if (rd_en)
      rd_desc <= rows[rd_idx];
  end
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
(
  input  logic            seg_ok,
  input  seg_desc_t       desc,
  input  logic [LEN_W-1:0] off,
  input  logic            is_write,
  output trap_t           trap,
  output logic [PA_W-1:0] paddr
);
  logic right_ok;

  always_comb begin
    right_ok = is_write ? desc.rights[WR_BIT] : desc.rights[RD_BIT];
    if (!seg_ok)
      trap = TRAP_SEG;
    else if (off >= desc.len)
      trap = TRAP_LIMIT;
    else if (!right_ok)
      trap = TRAP_PROT;
    else
      trap = TRAP_NONE;
    paddr = (trap == TRAP_NONE) ? (PA_W'(desc.base) + PA_W'(off)) : '0;
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import segx_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int SEG_W = 5,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int LREG_W = SEG_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supervisor,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [BASE_W-1:0]   cfg_base,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [RIGHTS_W-1:0] cfg_rights,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [LEN_W-1:0]    req_off,
  input  logic                req_write,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [1:0]          rsp_trap
);
  logic              cfg_ok;
  logic [IDX_W-1:0]  tbase_q;
  logic [LREG_W-1:0] tlen_q;
  seg_desc_t         wr_desc;
  seg_desc_t         s1_desc;
  logic              s1_v, s1_segok, s1_wr;
  logic [LEN_W-1:0]  s1_off;
  logic              s2_load, accept;
  logic [IDX_W-1:0]  slot;
  trap_t             chk_trap;
  logic [PA_W-1:0]   chk_paddr;

  assign cfg_ok = cfg_we && supervisor;

  // Control registers, guarded by the mode input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbase_q <= '0;
      tlen_q  <= '0;
    end else if (cfg_ok) begin
      if (cfg_kind == CFG_TBASE) tbase_q <= cfg_len[IDX_W-1:0];
      if (cfg_kind == CFG_TLEN)  tlen_q  <= cfg_len[LREG_W-1:0];
    end
  end

  assign wr_desc = '{base: cfg_base, len: cfg_len, rights: cfg_rights};

  // Stream control: output register frees when empty or consumed.
  assign s2_load   = !rsp_valid || rsp_ready;
  assign req_ready = !s1_v || s2_load;
  assign accept    = req_valid && req_ready;
  assign slot      = tbase_q + req_seg[IDX_W-1:0];

  segx_desc_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_ok && (cfg_kind == CFG_ENTRY)),
    .wr_idx  (cfg_idx),
    .wr_desc (wr_desc),
    .rd_en   (accept),
    .rd_idx  (slot),
    .rd_desc (s1_desc)
  );

  // Stage 1: request fields captured alongside the descriptor read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_segok <= 1'b0;
      s1_wr    <= 1'b0;
      s1_off   <= '0;
    end else if (accept) begin
      s1_v     <= 1'b1;
      s1_segok <= (LREG_W'(req_seg) < tlen_q);
      s1_wr    <= req_write;
      s1_off   <= req_off;
    end else if (s2_load) begin
      s1_v <= 1'b0;
    end
  end

  segx_check u_check (
    .seg_ok   (s1_segok),
    .desc     (s1_desc),
    .off      (s1_off),
    .is_write (s1_wr),
    .trap     (chk_trap),
    .paddr    (chk_paddr)
  );

  // Stage 2: result register on the output stream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_trap  <= '0;
    end else if (s2_load) begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_paddr <= chk_paddr;
        rsp_trap  <= chk_trap;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_trap)));

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && rsp_valid && !rsp_ready) |-> !req_ready);

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> s1_v);

  assert_deliver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && (!rsp_valid || rsp_ready)) |=> rsp_valid);

  assert_seg_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_segok && (!rsp_valid || rsp_ready)) |=> (rsp_trap == TRAP_SEG && rsp_paddr == '0));

  assert_user_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supervisor |=> ($stable(tbase_q) && $stable(tlen_q)));
endmodule

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;
  import segx_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, supervisor, cfg_we;
  logic [1:0]  cfg_kind;
  logic [3:0]  cfg_idx;
  logic [19:0] cfg_base;
  logic [15:0] cfg_len;
  logic [1:0]  cfg_rights;
  logic        req_valid, req_ready, req_write;
  logic [4:0]  req_seg;
  logic [15:0] req_off;
  logic        rsp_valid, rsp_ready;
  logic [20:0] rsp_paddr;
  logic [1:0]  rsp_trap;

  seg_xlat u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // Behavioural reference state.
  int m_base [16], m_len [16], m_rt [16];
  int m_tb, m_tl;
  bit m1_v, m2_v;
  int m1_pa, m1_tr, m2_pa, m2_tr;

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic mdl_xlat(int seg, int off, bit wr, output int pa, output int tr);
    int s;
    s = (m_tb + seg) % 16;
    pa = 0;
    if (seg >= m_tl) tr = 1;
    else if (off >= m_len[s]) tr = 2;
    else if (((m_rt[s] >> (wr ? 1 : 0)) & 1) == 0) tr = 3;
    else begin tr = 0; pa = m_base[s] + off; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_len[i] = 0; m_rt[i] = 0; end
      m_tb = 0; m_tl = 0; m1_v = 0; m2_v = 0;
    end else begin
      bit s2l, acc;
      s2l = !m2_v || rsp_ready;
      acc = req_valid && (!m1_v || s2l);
      if (s2l) begin
        m2_v = m1_v;
        if (m1_v) begin m2_pa = m1_pa; m2_tr = m1_tr; end
      end
      if (acc) begin
        m1_v = 1;
        mdl_xlat(int'(req_seg), int'(req_off), req_write, m1_pa, m1_tr);
      end else if (s2l) m1_v = 0;
      if (cfg_we && supervisor) begin
        case (cfg_kind)
          2'd0: begin m_base[cfg_idx] = cfg_base; m_len[cfg_idx] = cfg_len; m_rt[cfg_idx] = cfg_rights; end
          2'd1: m_tb = cfg_len[3:0];
          2'd2: m_tl = cfg_len[5:0];
          default: ;
        endcase
      end
    end
  end

  // Every-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R10 req_ready vs model", req_ready, (!m1_v || !m2_v || rsp_ready));
      chk("R9 rsp_valid vs model", rsp_valid, m2_v);
      if (m2_v) begin
        string t;
        t = (m2_tr == 0) ? "R4" : (m2_tr == 1) ? "R2" : (m2_tr == 2) ? "R3" : "R5";
        chk({t, " model paddr"}, rsp_paddr, m2_pa);
        chk({t, " model trap"}, rsp_trap, m2_tr);
      end
    end
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic cfg(int kind, int idx, int base, int len, int rt, bit sup);
    @(negedge clk); #1;
    cfg_we = 1; cfg_kind = 2'(kind); cfg_idx = 4'(idx); cfg_base = 20'(base);
    cfg_len = 16'(len); cfg_rights = 2'(rt); supervisor = sup;
    @(negedge clk); #1;
    cfg_we = 0; supervisor = 0;
  endtask

  // One request through an idle pipeline with the consumer ready.
  task automatic xact(int seg, int off, bit wr, int exp_pa, int exp_tr, string tag);
    @(negedge clk); #1;
    req_valid = 1; req_seg = 5'(seg); req_off = 16'(off); req_write = wr;
    @(negedge clk);
    chk({tag, " R9 not yet valid"}, rsp_valid, 0);
    #1 req_valid = 0;
    @(negedge clk);
    chk({tag, " R9 valid after one more edge"}, rsp_valid, 1);
    chk({tag, " paddr"}, rsp_paddr, exp_pa);
    chk({tag, " trap"}, rsp_trap, exp_tr);
  endtask

  initial begin
    rst_n = 0; supervisor = 0; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_base = 0;
    cfg_len = 0; cfg_rights = 0; req_valid = 0; req_seg = 0; req_off = 0;
    req_write = 0; rsp_ready = 1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    xact(0, 0, 0, 0, 1, "R1 empty length traps");

    cfg(2, 0, 0, 5, 0, 1);
    cfg(0, 0, 219, 600, 3, 1);
    cfg(0, 1, 2300, 14, 1, 1);
    cfg(0, 2, 90, 100, 3, 1);
    cfg(0, 3, 1327, 580, 2, 1);
    cfg(0, 4, 1952, 96, 3, 1);

    xact(0, 430, 0, 649, 0, "R4 219+430");
    xact(1, 10, 0, 2310, 0, "R4 2300+10");
    xact(1, 13, 0, 2313, 0, "R3 last byte ok");
    xact(1, 14, 0, 0, 2, "R3 offset equal length");
    xact(2, 500, 0, 0, 2, "R3 offset past length");
    xact(4, 112, 0, 0, 2, "R3 seg4 offset 112");
    xact(3, 400, 0, 0, 3, "R5 read without read right");
    xact(3, 400, 1, 1727, 0, "R5 write allowed");
    xact(1, 5, 1, 0, 3, "R5 write without write right");
    xact(5, 0, 0, 0, 1, "R2 seg equal length");
    xact(31, 3, 0, 0, 1, "R2 seg far above length");
    xact(1, 14, 1, 0, 2, "R6 limit beats rights");
    xact(7, 60000, 1, 0, 1, "R6 seg beats limit");

    cfg(2, 0, 0, 1, 0, 0);
    xact(4, 0, 0, 1952, 0, "R8 user length write ignored");
    cfg(0, 0, 7, 600, 3, 0);
    xact(0, 1, 0, 220, 0, "R8 user entry write ignored");
    cfg(3, 0, 0, 0, 0, 1);
    xact(0, 2, 0, 221, 0, "R8 kind 3 has no effect");

    cfg(1, 0, 0, 2, 0, 1);
    xact(0, 5, 0, 95, 0, "R7 base 2 seg 0");
    xact(2, 3, 0, 1955, 0, "R7 base 2 seg 2");
    cfg(1, 0, 0, 14, 0, 1);
    xact(2, 1, 0, 220, 0, "R7 wrap to slot 0");
    cfg(1, 0, 0, 0, 0, 1);

    // R11: a write at the accepting edge does not reach that request.
    @(negedge clk); #1;
    req_valid = 1; req_seg = 0; req_off = 1; req_write = 0;
    cfg_we = 1; supervisor = 1; cfg_kind = 0; cfg_idx = 0; cfg_base = 1000; cfg_len = 600; cfg_rights = 3;
    @(negedge clk); #1;
    req_valid = 0; cfg_we = 0; supervisor = 0;
    @(negedge clk);
    chk("R11 old base used", rsp_paddr, 220);
    xact(0, 1, 0, 1001, 0, "R11 new base afterwards");
    cfg(0, 0, 219, 600, 3, 1);

    // R10: stall the consumer with two requests in flight.
    @(negedge clk); #1;
    rsp_ready = 0; req_valid = 1; req_seg = 0; req_off = 10; req_write = 0;
    @(negedge clk); #1 req_off = 20;
    @(negedge clk); #1 req_off = 30;
    @(negedge clk);
    chk("R10 req_ready low when full", req_ready, 0);
    chk("R10 held paddr", rsp_paddr, 229);
    repeat (3) @(negedge clk);
    chk("R10 paddr still held", rsp_paddr, 229);
    chk("R10 still valid", rsp_valid, 1);
    #1 req_valid = 0; rsp_ready = 1;
    repeat (4) @(negedge clk);

    // Random stream with back-pressure and mixed configuration writes.
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      req_valid = ($urandom % 3) != 0;
      req_seg = 5'($urandom % 8);
      req_off = 16'($urandom % 700);
      req_write = 1'($urandom % 2);
      rsp_ready = ($urandom % 4) != 0;
      cfg_we = ($urandom % 16) == 0;
      supervisor = 1'($urandom % 2);
      cfg_kind = 2'($urandom % 4);
      cfg_idx = 4'($urandom % 16);
      cfg_base = 20'($urandom % 5000);
      cfg_len = (cfg_kind == 2'd2) ? 16'(3 + $urandom % 6) : 16'($urandom % 700);
      cfg_rights = 2'($urandom % 4);
    end
    @(negedge clk); #1;
    req_valid = 0; cfg_we = 0; rsp_ready = 1;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule